// File: doc/BRIEF.md
# Conversion Interrupt Status Unit

This block collects conversion-finished pulses and conversion-overrun detections for four converter channels. Each is recorded in a sticky status word, and the block raises a single interrupt line. Two enable words sit at different points. The capture mask decides whether an event is recorded in the status word at all. The signal mask decides which recorded bits may reach the interrupt line.

Software uses a small synchronous register port to read the status word and clears bits by writing zeros to them. For each channel the block also runs a cycle counter. A start pulse arms the counter, and a finish pulse stops it. If the counter reaches a programmable limit before the finish pulse arrives, the block records an overrun for that channel.

Top module: `conv_irq_status`

## Requirements
- R1: After reset, the status word, both enable words and the limit read as zero, and `irq` is low.
- R2: A pulse on `conv_done[i]` sets status bit 8+i at the next clock edge, provided capture-mask bit 8+i is set. If that capture-mask bit is clear, the status bit is not set.
- R3: After `conv_start[i]` is sampled at edge t with limit L>0 and capture-mask bit 16+i set, status bit 16+i becomes set at edge t+L if no `conv_done[i]` is sampled at any edge t+1..t+L. Any such finish pulse cancels the overrun. A limit of 0 disables overrun detection.
- R4: Reading any register has no effect on the status word. A status bit falls only through a write to address 0.
- R5: A write to the status word (address 0) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: If an event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some status bit is set whose signal-mask bit (address 2) is also set. The signal mask has no effect on which events are captured.
- R8: Only bits 8..11 and 16..19 exist in the status word and both masks. All other bits read 0 and ignore writes. The capture mask is at address 1, and the limit is at address 3 in the low 16 bits.
- R9: A new `conv_start[i]` while channel i is armed restarts its count, so the overrun falls L edges after the latest start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | input | NCH | Per-channel conversion start pulse |
| conv_done | input | NCH | Per-channel conversion finished pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 capture mask, 2 signal mask, 3 limit |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same status bit in the same cycle: event capture and the write-zero clear. The same applies to a finish pulse and an overrun detection on the same channel. The bench provokes the first collision directly, with a clearing write issued alongside a finish pulse, and checks that the bit stays set. It provokes the second by timing the finish pulse to arrive on the exact edge where the limit would be met, and checks that no overrun is recorded. Random traffic then lays dense writes over events, and every register and `irq` are compared each cycle against a reference model in the bench.

// File: rtl/conv_irq_status.sv
module conv_irq_status #(
  parameter int NCH      = 4,
  parameter int DONE_LSB = 8,
  parameter int TMO_LSB  = 16,
  parameter int DW       = 32,
  parameter int TW       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] conv_start,
  input  logic [NCH-1:0] conv_done,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq
);
  localparam logic [DW-1:0] DONE_MASK = DW'({NCH{1'b1}}) << DONE_LSB;
  localparam logic [DW-1:0] TMO_MASK  = DW'({NCH{1'b1}}) << TMO_LSB;
  localparam logic [DW-1:0] IMPL_MASK = DONE_MASK | TMO_MASK;
  localparam logic [1:0] A_STAT = 2'd0, A_CAPT = 2'd1, A_SIGN = 2'd2, A_LIM = 2'd3;
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [DW-1:0]  stat_q, capt_q, sign_q, evt_raw, evt_set;
  logic [TW-1:0]  lim_q;
  logic [NCH-1:0] tmo_evt;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic          run_q;
    logic [TW-1:0] cnt_q;

    assign tmo_evt[ch] = run_q && (lim_q != '0) && (cnt_q == lim_q) && !conv_done[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (conv_start[ch]) begin
        run_q <= 1'b1;
        cnt_q <= TW'(1);
      end else if (conv_done[ch] || tmo_evt[ch]) begin
        run_q <= 1'b0;
      end else if (run_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  always_comb begin
    evt_raw = '0;
    evt_raw[DONE_LSB +: NCH] = conv_done;
    evt_raw[TMO_LSB  +: NCH] = tmo_evt;
  end
  assign evt_set = evt_raw & capt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      capt_q <= '0;
      sign_q <= '0;
      lim_q  <= '0;
    end else begin
      stat_q <= (((reg_we && reg_addr == A_STAT) ? (stat_q & reg_wdata) : stat_q) | evt_set) & IMPL_MASK;
      if (reg_we && reg_addr == A_CAPT) capt_q <= reg_wdata & IMPL_MASK;
      if (reg_we && reg_addr == A_SIGN) sign_q <= reg_wdata & IMPL_MASK;
      if (reg_we && reg_addr == A_LIM)  lim_q  <= reg_wdata[TW-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat_q;
      A_CAPT:  reg_rdata = capt_q;
      A_SIGN:  reg_rdata = sign_q;
      default: reg_rdata = DW'(lim_q);
    endcase
  end

  assign irq = |(stat_q & sign_q);
endmodule

module conv_irq_status_chk #(
  parameter int NCH      = 4,
  parameter int DONE_LSB = 8,
  parameter int TMO_LSB  = 16,
  parameter int DW       = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] conv_done,
  input logic           reg_we,
  input logic [1:0]     reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [DW-1:0]  reg_rdata,
  input logic           irq,
  input logic [DW-1:0]  stat_q,
  input logic [DW-1:0]  capt_q,
  input logic [DW-1:0]  sign_q,
  input logic [DW-1:0]  evt_set
);
  localparam logic [DW-1:0] IMPL_MASK = (DW'({NCH{1'b1}}) << DONE_LSB) | (DW'({NCH{1'b1}}) << TMO_LSB);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (stat_q == '0 && !irq));

  // R4
  no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 2'd0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R5
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> ((stat_q & $past(stat_q & reg_wdata)) == $past(stat_q & reg_wdata)));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((stat_q & $past(evt_set)) == $past(evt_set)));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_q & sign_q) != '0));

  // R8
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 2'd3) |-> ((reg_rdata & ~IMPL_MASK) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_cap
    // R2
    done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[DONE_LSB+g]) |-> $past(capt_q[DONE_LSB+g] && conv_done[g]));
    // R3
    tmo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[TMO_LSB+g]) |-> $past(capt_q[TMO_LSB+g]));
  end
endmodule

bind conv_irq_status conv_irq_status_chk #(
  .NCH(NCH), .DONE_LSB(DONE_LSB), .TMO_LSB(TMO_LSB), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .stat_q(stat_q), .capt_q(capt_q), .sign_q(sign_q), .evt_set(evt_set)
);

// File: tb/conv_irq_status_tb_top.sv
`timescale 1ns/1ps
module conv_irq_status_tb_top;
  localparam logic [31:0] MASK = 32'h000F_0F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  conv_start = '0, conv_done = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_stat = '0, m_capt = '0, m_sign = '0;
  logic [15:0] m_lim = '0;
  bit          m_run [4];
  logic [15:0] m_cnt [4];

  always #2.5 clk = ~clk;

  conv_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_stat & m_sign);
  endfunction

  task automatic model_edge();
    logic [31:0] evt = '0;
    for (int ch = 0; ch < 4; ch++) begin
      bit tevt = m_run[ch] && m_lim != 0 && m_cnt[ch] == m_lim && !conv_done[ch];
      evt[8+ch]  = conv_done[ch];
      evt[16+ch] = tevt;
      if (conv_start[ch]) begin m_run[ch] = 1; m_cnt[ch] = 16'd1; end
      else if (conv_done[ch] || tevt) m_run[ch] = 0;
      else if (m_run[ch] && m_cnt[ch] != 16'hFFFF) m_cnt[ch] = m_cnt[ch] + 16'd1;
    end
    m_stat = (((reg_we && reg_addr == 2'd0) ? (m_stat & reg_wdata) : m_stat) | (evt & m_capt)) & MASK;
    if (reg_we && reg_addr == 2'd1) m_capt = reg_wdata & MASK;
    if (reg_we && reg_addr == 2'd2) m_sign = reg_wdata & MASK;
    if (reg_we && reg_addr == 2'd3) m_lim  = reg_wdata[15:0];
  endtask

  task automatic step(input logic [3:0] st, input logic [3:0] dn,
                      input logic we, input logic [1:0] a, input logic [31:0] wd);
    conv_start = st; conv_done = dn; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    conv_start = '0; conv_done = '0; reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 1'b0, 2'd0, '0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] wd);
    step('0, '0, 1'b1, a, wd);
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic compare_all(input string req);
    logic [31:0] v;
    peek(2'd0, v); chk({req, " status"}, v, m_stat);
    peek(2'd1, v); chk({req, " capture"}, v, m_capt);
    peek(2'd2, v); chk({req, " signal"}, v, m_sign);
    peek(2'd3, v); chk({req, " limit"}, v, {16'h0, m_lim});
    chk("R7 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int ch = 0; ch < 4; ch++) begin m_run[ch] = 0; m_cnt[ch] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd0, v); chk("R1 status", v, 32'h0);
    peek(2'd1, v); chk("R1 capture", v, 32'h0);
    peek(2'd3, v); chk("R1 limit", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R8 unused bits dropped
    wr(2'd1, 32'hFFFF_FFFF);
    peek(2'd1, v); chk("R8 capture mask", v, MASK);

    // R2 done capture, R7 signal mask gates irq only
    step(4'b0100, 4'b0100, 1'b0, 2'd0, '0);
    step('0, 4'b0100, 1'b0, 2'd0, '0);
    peek(2'd0, v); chk("R2 done ch2", v, 32'h0000_0400);
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    wr(2'd2, 32'h0000_0400);
    chk("R7 irq enabled", {31'h0, irq}, 32'h1);

    // R4 repeated reads keep status
    for (int i = 0; i < 3; i++) begin peek(2'd0, v); idle(1); end
    peek(2'd0, v); chk("R4 status after reads", v, 32'h0000_0400);

    // R5 write ones keeps, write zero clears
    wr(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, v); chk("R5 ones keep", v, 32'h0000_0400);
    wr(2'd0, ~32'h0000_0400);
    peek(2'd0, v); chk("R5 zero clears", v, 32'h0);
    chk("R7 irq drops", {31'h0, irq}, 32'h0);

    // R2 capture mask off for ch1
    wr(2'd1, MASK & ~32'h0000_0200);
    step('0, 4'b0010, 1'b0, 2'd0, '0);
    peek(2'd0, v); chk("R2 masked done", v, 32'h0);
    wr(2'd1, MASK);

    // R3 overrun exactly at limit
    wr(2'd3, 32'd5);
    step(4'b0001, '0, 1'b0, 2'd0, '0);
    idle(4);
    peek(2'd0, v); chk("R3 before limit", v, 32'h0);
    idle(1);
    peek(2'd0, v); chk("R3 at limit", v, 32'h0001_0000);
    wr(2'd0, 32'h0);

    // R3 finish on the deciding edge cancels overrun
    step(4'b1000, '0, 1'b0, 2'd0, '0);
    idle(4);
    step('0, 4'b1000, 1'b0, 2'd0, '0);
    idle(8);
    peek(2'd0, v); chk("R3 finish wins", v, 32'h0000_0800);
    wr(2'd0, 32'h0);

    // R6 clearing write and event in same cycle
    wr(2'd0, 32'h0); step('0, 4'b0001, 1'b0, 2'd0, '0);
    step('0, 4'b0001, 1'b1, 2'd0, 32'h0);
    peek(2'd0, v); chk("R6 event wins", v, 32'h0000_0100);
    wr(2'd0, 32'h0);

    // R9 restart
    step(4'b0010, '0, 1'b0, 2'd0, '0);
    idle(3);
    step(4'b0010, '0, 1'b0, 2'd0, '0);
    idle(4);
    peek(2'd0, v); chk("R9 restarted count", v, 32'h0);
    idle(1);
    peek(2'd0, v); chk("R9 overrun after restart", v, 32'h0002_0000);
    wr(2'd0, 32'h0);

    // R3 limit zero disables
    wr(2'd3, 32'd0);
    step(4'b0100, '0, 1'b0, 2'd0, '0);
    idle(20);
    peek(2'd0, v); chk("R3 limit zero", v, 32'h0);
    compare_all("R2 model sync");

    // Random mix against bench model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  st = '0, dn = '0;
      logic        we = ($urandom % 5) == 0;
      logic [1:0]  a  = 2'($urandom % 4);
      logic [31:0] wd = $urandom;
      for (int ch = 0; ch < 4; ch++) begin
        st[ch] = ($urandom % 14) == 0;
        dn[ch] = ($urandom % 11) == 0;
      end
      if (a == 2'd3) wd = $urandom % 13;
      if (a != 2'd0 && ($urandom % 3) != 0) we = 1'b0;
      step(st, dn, we, a, wd);
      compare_all("R5 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule